// File: doc/BRIEF.md
# Dual Chip-Select Address Decoder

This block sits at the front of an SDRAM controller and decides, for every request on the interconnect, which of two external memory devices it targets. The controller owns a 1 GB address window cut into eight equal slots of 128 MB. The first device is always placed at the bottom of the window. The second device begins at a slot picked by configuration. Each device covers only as many bytes as its programmed size, counted in 2 MB units and never past the top of the window. The block returns the chosen device, the byte offset inside that device, and a miss flag for addresses that no device covers. Gaps between or above the devices are reported as misses and are never aliased onto a device.

Three configuration flags are produced alongside the decode. One reports that the two device ranges overlap; the bottom device then wins. One reports that the second device's start slot lies outside the window, which disables that device. One reports that the two populated devices are of different memory families (single and double data rate), which is not a legal pairing. The decode result and all flags are registered, so they appear one clock after the request or configuration is presented.

Top module: `dcs_addr_decoder`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, rsp_valid, rsp_cs, rsp_offset, rsp_err and all three flags are zero, whatever the inputs are doing.
- R2: rsp_valid equals the previous cycle's req_valid, and the response then describes the address presented in that cycle; when req_valid was low, rsp_cs, rsp_offset and rsp_err keep their values.
- R3: Device 0 spans byte offsets from 0 up to (but not including) cfg_cs0_size times 2 MB; an address inside it gives rsp_cs = 0 and rsp_offset equal to the address.
- R4: Device 1 starts at slot number cfg_cs1_slot_hi*4 + cfg_cs1_slot_lo, that is at that number times 128 MB, and spans cfg_cs1_size times 2 MB; an address inside it and not inside device 0 gives rsp_cs = 1 and rsp_offset equal to the address minus the start.
- R5: An address inside neither device gives rsp_err = 1 with rsp_cs = 0 and rsp_offset = 0.
- R6: A size field of zero leaves that device with no addresses at all.
- R7: A device range whose size would pass the top of the 1 GB window ends at the window's top, so every address up to the last byte of the window still decodes.
- R8: When both devices are populated and their ranges share an address, flag_overlap is 1 one clock later and addresses in the shared part go to device 0.
- R9: When the device 1 start slot number is 8 or greater, flag_slot is 1 one clock later and device 1 decodes no address.
- R10: flag_mix is 1 one clock after both size fields are nonzero with cfg_cs0_ddr differing from cfg_cs1_ddr; a device whose size is zero never causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request address is presented this cycle |
| req_addr | input | 30 | Byte address inside the controller window |
| cfg_cs0_size | input | 10 | Device 0 size in 2 MB units |
| cfg_cs1_size | input | 10 | Device 1 size in 2 MB units |
| cfg_cs1_slot_lo | input | 2 | Low part of the device 1 start slot number |
| cfg_cs1_slot_hi | input | 4 | High part of the device 1 start slot number |
| cfg_cs0_ddr | input | 1 | Device 0 is double data rate (1) or single data rate (0) |
| cfg_cs1_ddr | input | 1 | Device 1 is double data rate (1) or single data rate (0) |
| rsp_valid | output | 1 | A decode result is present |
| rsp_cs | output | 1 | Selected device, 0 or 1 |
| rsp_offset | output | 30 | Byte offset inside the selected device |
| rsp_err | output | 1 | Address hit no device |
| flag_overlap | output | 1 | The two device ranges overlap |
| flag_mix | output | 1 | Populated devices are of different data-rate families |
| flag_slot | output | 1 | Device 1 start slot lies outside the window |

## Verification
The bench builds the decoder with its default parameters: a 30-bit window of eight slots, a 10-bit size field in 2 MB units and a 6-bit start slot split 2 plus 4. With these values a size of 512 or 1023 runs past the window top and exercises the clamp, a start field of 8 or more reaches slots beyond the window, and a start field with both parts nonzero checks how the two parts combine. The vectors probe the first and last byte of each device, the first byte past each device, the gap between them, the overlap case where the bottom device wins, and both sizes at zero.

// File: rtl/dcs_dec_pkg.sv
package dcs_dec_pkg;

   // Number of chip-selects handled by the decoder.
   localparam int unsigned NUM_CS = 2;

   // Identity of the selected device.
   typedef enum logic [0:0] {
      CS_BOTTOM = 1'b0,
      CS_MOVABLE = 1'b1
   } cs_id_e;

endpackage

// File: rtl/dcs_window.sv
// Computes the byte range [lo, hi) one device occupies in the window.
module dcs_window #(
   parameter int unsigned ADDR_W    = 30,
   parameter int unsigned SLOT_W    = 3,
   parameter int unsigned SIZE_W    = 10,
   parameter int unsigned UNIT_LOG2 = 21,
   parameter int unsigned START_W   = 6
) (
   input  logic [START_W-1:0] slot_i,
   input  logic [SIZE_W-1:0]  size_i,
   output logic [ADDR_W-1:0]  lo_o,
   output logic [ADDR_W:0]    hi_o,
   output logic               active_o,
   output logic               slot_bad_o
);

   localparam int unsigned SLOT_SHIFT = ADDR_W - SLOT_W;
   localparam int unsigned NUM_SLOTS  = 1 << SLOT_W;
   localparam int unsigned EXT_W      = ADDR_W + 1;
   localparam int unsigned CALC_W     = ADDR_W + SIZE_W + 2;
   localparam logic [CALC_W-1:0] WIN_C = CALC_W'(1) << ADDR_W;

   logic              slot_ok;
   logic [CALC_W-1:0] base_w;
   logic [CALC_W-1:0] span_w;
   logic [CALC_W-1:0] end_w;

   always_comb begin
      slot_ok    = 32'(slot_i) < NUM_SLOTS;
      base_w     = slot_ok ? (CALC_W'(slot_i) << SLOT_SHIFT) : '0;
      span_w     = CALC_W'(size_i) << UNIT_LOG2;
      end_w      = base_w + span_w;
      lo_o       = ADDR_W'(base_w);
      hi_o       = (end_w > WIN_C) ? EXT_W'(WIN_C) : EXT_W'(end_w);
      active_o   = slot_ok && (size_i != '0);
      slot_bad_o = !slot_ok;
   end

endmodule

// File: rtl/dcs_match.sv
// Compares an address against every device range, lowest index wins.
module dcs_match #(
   parameter int unsigned ADDR_W = 30,
   parameter int unsigned NUM_CS = 2,
   parameter int unsigned IDX_W  = 1
) (
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic [NUM_CS-1:0][ADDR_W-1:0]  lo_i,
   input  logic [NUM_CS-1:0][ADDR_W:0]    hi_i,
   input  logic [NUM_CS-1:0]              active_i,
   output logic [IDX_W-1:0]               sel_o,
   output logic                           miss_o,
   output logic [ADDR_W-1:0]              off_o
);

   logic [NUM_CS-1:0] hit;

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
      assign hit[g] = active_i[g]
                   && ({1'b0, addr_i} >= {1'b0, lo_i[g]})
                   && ({1'b0, addr_i} <  hi_i[g]);
   end

   always_comb begin
      sel_o  = '0;
      miss_o = 1'b1;
      for (int i = NUM_CS - 1; i >= 0; i--) begin
         if (hit[i]) begin
            sel_o  = IDX_W'(i);
            miss_o = 1'b0;
         end
      end
      off_o = addr_i - lo_i[sel_o];
   end

endmodule

// File: rtl/dcs_cfg_check.sv
// Pairwise configuration checks: range overlap and data-rate mixing.
module dcs_cfg_check #(
   parameter int unsigned ADDR_W = 30,
   parameter int unsigned NUM_CS = 2
) (
   input  logic [NUM_CS-1:0][ADDR_W-1:0] lo_i,
   input  logic [NUM_CS-1:0][ADDR_W:0]   hi_i,
   input  logic [NUM_CS-1:0]             active_i,
   input  logic [NUM_CS-1:0]             ddr_i,
   input  logic [NUM_CS-1:0]             populated_i,
   output logic                          overlap_o,
   output logic                          mix_o
);

   always_comb begin
      overlap_o = 1'b0;
      mix_o     = 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
         for (int j = i + 1; j < NUM_CS; j++) begin
            if (active_i[i] && active_i[j]
                && ({1'b0, lo_i[i]} < hi_i[j])
                && ({1'b0, lo_i[j]} < hi_i[i]))
               overlap_o = 1'b1;
            if (populated_i[i] && populated_i[j] && (ddr_i[i] != ddr_i[j]))
               mix_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dcs_addr_decoder.sv
module dcs_addr_decoder
   import dcs_dec_pkg::*;
#(
   parameter int unsigned ADDR_W    = 30,
   parameter int unsigned SLOT_W    = 3,
   parameter int unsigned SIZE_W    = 10,
   parameter int unsigned UNIT_LOG2 = 21,
   parameter int unsigned LO_W      = 2,
   parameter int unsigned HI_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] cfg_cs0_size,
   input  logic [SIZE_W-1:0] cfg_cs1_size,
   input  logic [LO_W-1:0]   cfg_cs1_slot_lo,
   input  logic [HI_W-1:0]   cfg_cs1_slot_hi,
   input  logic              cfg_cs0_ddr,
   input  logic              cfg_cs1_ddr,
   output logic              rsp_valid,
   output logic              rsp_cs,
   output logic [ADDR_W-1:0] rsp_offset,
   output logic              rsp_err,
   output logic              flag_overlap,
   output logic              flag_mix,
   output logic              flag_slot
);

   localparam int unsigned START_W = LO_W + HI_W;
   localparam int unsigned IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

   // Elaboration-time parameter checks.
   if (SLOT_W < 1 || SLOT_W >= ADDR_W) begin : g_bad_slot_w
      $error("SLOT_W must lie between 1 and ADDR_W-1");
   end
   if (UNIT_LOG2 >= ADDR_W) begin : g_bad_unit
      $error("UNIT_LOG2 must be below ADDR_W");
   end
   if (START_W < SLOT_W) begin : g_bad_start_w
      $error("start slot fields too narrow for the slot count");
   end
   if (NUM_CS != 2) begin : g_bad_cs
      $error("decoder port list assumes two chip-selects");
   end

   logic [NUM_CS-1:0][START_W-1:0] slot_w;
   logic [NUM_CS-1:0][SIZE_W-1:0]  size_w;
   logic [NUM_CS-1:0][ADDR_W-1:0]  lo_w;
   logic [NUM_CS-1:0][ADDR_W:0]    hi_w;
   logic [NUM_CS-1:0]              active_w;
   logic [NUM_CS-1:0]              slot_bad_w;
   logic [NUM_CS-1:0]              ddr_w;
   logic [NUM_CS-1:0]              populated_w;

   always_comb begin
      slot_w[0] = '0;                          // bottom device is pinned
      slot_w[1] = {cfg_cs1_slot_hi, cfg_cs1_slot_lo};
      size_w[0] = cfg_cs0_size;
      size_w[1] = cfg_cs1_size;
      ddr_w     = {cfg_cs1_ddr, cfg_cs0_ddr};
      for (int k = 0; k < NUM_CS; k++)
         populated_w[k] = size_w[k] != '0;
   end

   for (genvar g = 0; g < NUM_CS; g++) begin : g_win
      dcs_window #(
         .ADDR_W   (ADDR_W),
         .SLOT_W   (SLOT_W),
         .SIZE_W   (SIZE_W),
         .UNIT_LOG2(UNIT_LOG2),
         .START_W  (START_W)
      ) u_win (
         .slot_i    (slot_w[g]),
         .size_i    (size_w[g]),
         .lo_o      (lo_w[g]),
         .hi_o      (hi_w[g]),
         .active_o  (active_w[g]),
         .slot_bad_o(slot_bad_w[g])
      );
   end

   logic [IDX_W-1:0]  sel_idx;
   logic              miss;
   logic [ADDR_W-1:0] off;
   cs_id_e            sel_cs;

   dcs_match #(
      .ADDR_W(ADDR_W),
      .NUM_CS(NUM_CS),
      .IDX_W (IDX_W)
   ) u_match (
      .addr_i  (req_addr),
      .lo_i    (lo_w),
      .hi_i    (hi_w),
      .active_i(active_w),
      .sel_o   (sel_idx),
      .miss_o  (miss),
      .off_o   (off)
   );

   logic overlap_c;
   logic mix_c;

   dcs_cfg_check #(
      .ADDR_W(ADDR_W),
      .NUM_CS(NUM_CS)
   ) u_cfg (
      .lo_i       (lo_w),
      .hi_i       (hi_w),
      .active_i   (active_w),
      .ddr_i      (ddr_w),
      .populated_i(populated_w),
      .overlap_o  (overlap_c),
      .mix_o      (mix_c)
   );

   assign sel_cs = miss ? CS_BOTTOM : cs_id_e'(sel_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_cs       <= 1'b0;
         rsp_offset   <= '0;
         rsp_err      <= 1'b0;
         flag_overlap <= 1'b0;
         flag_mix     <= 1'b0;
         flag_slot    <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         if (req_valid) begin
            rsp_cs     <= (sel_cs == CS_MOVABLE);
            rsp_err    <= miss;
            rsp_offset <= miss ? '0 : off;
         end
         flag_overlap <= overlap_c;
         flag_mix     <= mix_c;
         flag_slot    <= |slot_bad_w;
      end
   end

endmodule

// File: rtl/dcs_addr_decoder_chk.sv
module dcs_addr_decoder_chk #(
   parameter int unsigned ADDR_W = 30,
   parameter int unsigned SLOT_W = 3,
   parameter int unsigned SIZE_W = 10,
   parameter int unsigned LO_W   = 2,
   parameter int unsigned HI_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [SIZE_W-1:0] cfg_cs0_size,
   input logic [SIZE_W-1:0] cfg_cs1_size,
   input logic [LO_W-1:0]   cfg_cs1_slot_lo,
   input logic [HI_W-1:0]   cfg_cs1_slot_hi,
   input logic              cfg_cs0_ddr,
   input logic              cfg_cs1_ddr,
   input logic              rsp_valid,
   input logic              rsp_cs,
   input logic [ADDR_W-1:0] rsp_offset,
   input logic              rsp_err,
   input logic              flag_overlap,
   input logic              flag_mix,
   input logic              flag_slot
);

   localparam int unsigned SLOT_SHIFT = ADDR_W - SLOT_W;
   localparam int unsigned NUM_SLOTS  = 1 << SLOT_W;

   // Set once a full clock has passed out of reset, so $past is meaningful.
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (rsp_valid == $past(req_valid)));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(req_valid)) |->
         ($stable(rsp_offset) && $stable(rsp_cs) && $stable(rsp_err)));

   p_bottom_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && rsp_valid && !rsp_err && !rsp_cs) |->
         (rsp_offset == $past(req_addr)));

   p_slot_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && rsp_valid && !rsp_err && rsp_cs) |->
         ((rsp_offset[SLOT_SHIFT-1:0] == $past(req_addr[SLOT_SHIFT-1:0]))
          && (rsp_offset <= $past(req_addr))));

   p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_offset == '0 && !rsp_cs));

   p_overlap_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && flag_overlap) |->
         $past(cfg_cs0_size != '0 && cfg_cs1_size != '0));

   p_slot_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (flag_slot ==
         (32'($past({cfg_cs1_slot_hi, cfg_cs1_slot_lo})) >= NUM_SLOTS)));

   p_mix_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && flag_mix) |->
         $past(cfg_cs0_ddr != cfg_cs1_ddr
               && cfg_cs0_size != '0 && cfg_cs1_size != '0));

endmodule

bind dcs_addr_decoder dcs_addr_decoder_chk #(
   .ADDR_W(ADDR_W),
   .SLOT_W(SLOT_W),
   .SIZE_W(SIZE_W),
   .LO_W  (LO_W),
   .HI_W  (HI_W)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_addr       (req_addr),
   .cfg_cs0_size   (cfg_cs0_size),
   .cfg_cs1_size   (cfg_cs1_size),
   .cfg_cs1_slot_lo(cfg_cs1_slot_lo),
   .cfg_cs1_slot_hi(cfg_cs1_slot_hi),
   .cfg_cs0_ddr    (cfg_cs0_ddr),
   .cfg_cs1_ddr    (cfg_cs1_ddr),
   .rsp_valid      (rsp_valid),
   .rsp_cs         (rsp_cs),
   .rsp_offset     (rsp_offset),
   .rsp_err        (rsp_err),
   .flag_overlap   (flag_overlap),
   .flag_mix       (flag_mix),
   .flag_slot      (flag_slot)
);

// File: tb/dcs_addr_decoder_tb_top.sv
module dcs_addr_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [29:0] req_addr = '0;
   logic [9:0]  cfg_cs0_size = '0;
   logic [9:0]  cfg_cs1_size = '0;
   logic [1:0]  cfg_cs1_slot_lo = '0;
   logic [3:0]  cfg_cs1_slot_hi = '0;
   logic        cfg_cs0_ddr = 1'b0;
   logic        cfg_cs1_ddr = 1'b0;
   logic        rsp_valid;
   logic        rsp_cs;
   logic [29:0] rsp_offset;
   logic        rsp_err;
   logic        flag_overlap;
   logic        flag_mix;
   logic        flag_slot;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dcs_addr_decoder dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_addr       (req_addr),
      .cfg_cs0_size   (cfg_cs0_size),
      .cfg_cs1_size   (cfg_cs1_size),
      .cfg_cs1_slot_lo(cfg_cs1_slot_lo),
      .cfg_cs1_slot_hi(cfg_cs1_slot_hi),
      .cfg_cs0_ddr    (cfg_cs0_ddr),
      .cfg_cs1_ddr    (cfg_cs1_ddr),
      .rsp_valid      (rsp_valid),
      .rsp_cs         (rsp_cs),
      .rsp_offset     (rsp_offset),
      .rsp_err        (rsp_err),
      .flag_overlap   (flag_overlap),
      .flag_mix       (flag_mix),
      .flag_slot      (flag_slot)
   );

   typedef struct packed {
      logic [9:0]  s0;
      logic [9:0]  s1;
      logic [5:0]  slot;   // {hi, lo}
      logic [29:0] addr;
      logic        cs;
      logic        err;
      logic [29:0] off;
      logic        ovl;
      logic        serr;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      // R3: bottom device, first bytes and last byte
      '{10'd64,   10'd64,  6'd4, 30'h0000_1234, 1'b0, 1'b0, 30'h0000_1234, 1'b0, 1'b0},
      '{10'd64,   10'd64,  6'd4, 30'h07FF_FFFF, 1'b0, 1'b0, 30'h07FF_FFFF, 1'b0, 1'b0},
      // R5: gap between devices
      '{10'd64,   10'd64,  6'd4, 30'h0800_0000, 1'b0, 1'b1, 30'h0000_0000, 1'b0, 1'b0},
      // R4: movable device first and last byte, then just past it
      '{10'd64,   10'd64,  6'd4, 30'h2000_0010, 1'b1, 1'b0, 30'h0000_0010, 1'b0, 1'b0},
      '{10'd64,   10'd64,  6'd4, 30'h27FF_FFFF, 1'b1, 1'b0, 30'h07FF_FFFF, 1'b0, 1'b0},
      '{10'd64,   10'd64,  6'd4, 30'h2800_0000, 1'b0, 1'b1, 30'h0000_0000, 1'b0, 1'b0},
      // R7: movable device in top slot, size past window top
      '{10'd1,    10'd512, 6'd7, 30'h3FFF_FFFF, 1'b1, 1'b0, 30'h07FF_FFFF, 1'b0, 1'b0},
      '{10'd1,    10'd512, 6'd7, 30'h001F_FFFF, 1'b0, 1'b0, 30'h001F_FFFF, 1'b0, 1'b0},
      '{10'd1,    10'd512, 6'd7, 30'h0020_0000, 1'b0, 1'b1, 30'h0000_0000, 1'b0, 1'b0},
      // R6: bottom device empty
      '{10'd0,    10'd64,  6'd0, 30'h0000_0010, 1'b1, 1'b0, 30'h0000_0010, 1'b0, 1'b0},
      // R4: slot number from hi=1, lo=1 is 5
      '{10'd8,    10'd8,   6'd5, 30'h2800_0004, 1'b1, 1'b0, 30'h0000_0004, 1'b0, 1'b0},
      // R8: overlapping ranges, bottom device wins in the shared part
      '{10'd128,  10'd128, 6'd1, 30'h0900_0000, 1'b0, 1'b0, 30'h0900_0000, 1'b1, 1'b0},
      '{10'd128,  10'd128, 6'd1, 30'h1000_0000, 1'b1, 1'b0, 30'h0800_0000, 1'b1, 1'b0},
      // R7: bottom device size past window top covers last word
      '{10'd1023, 10'd0,   6'd0, 30'h3FFF_FFFC, 1'b0, 1'b0, 30'h3FFF_FFFC, 1'b0, 1'b0},
      // R9: start slot 8 is outside the window
      '{10'd8,    10'd64,  6'd8, 30'h0000_0000, 1'b0, 1'b0, 30'h0000_0000, 1'b0, 1'b1},
      '{10'd8,    10'd64,  6'd8, 30'h3000_0000, 1'b0, 1'b1, 30'h0000_0000, 1'b0, 1'b1},
      // R6: both devices empty
      '{10'd0,    10'd0,   6'd0, 30'h0000_0000, 1'b0, 1'b1, 30'h0000_0000, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic outputs_zero(input string req);
      chk(req, 64'(rsp_valid), 64'd0);
      chk(req, 64'(rsp_cs), 64'd0);
      chk(req, 64'(rsp_offset), 64'd0);
      chk(req, 64'(rsp_err), 64'd0);
      chk(req, 64'({flag_overlap, flag_mix, flag_slot}), 64'd0);
   endtask

   initial begin
      // R1: outputs stay cleared in reset while inputs move
      cfg_cs0_size = 10'd64;
      cfg_cs1_size = 10'd64;
      cfg_cs0_ddr  = 1'b1;
      cfg_cs1_slot_hi = 4'd3;
      req_valid    = 1'b1;
      req_addr     = 30'h0000_0040;
      repeat (3) @(negedge clk);
      outputs_zero("R1 in reset");
      @(negedge clk);
      req_valid = 1'b0;
      rst_n     = 1'b1;
      #1;
      outputs_zero("R1 after release");
      cfg_cs0_ddr = 1'b0;
      cfg_cs1_slot_hi = 4'd0;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         cfg_cs0_size    = VECS[v].s0;
         cfg_cs1_size    = VECS[v].s1;
         cfg_cs1_slot_hi = VECS[v].slot[5:2];
         cfg_cs1_slot_lo = VECS[v].slot[1:0];
         req_addr        = VECS[v].addr;
         req_valid       = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         req_addr  = 30'h3FFF_FFF0;
         chk($sformatf("R2 valid vec %0d", v), 64'(rsp_valid), 64'd1);
         chk($sformatf("R3/R4 cs vec %0d", v), 64'(rsp_cs), 64'(VECS[v].cs));
         chk($sformatf("R5 err vec %0d", v), 64'(rsp_err), 64'(VECS[v].err));
         chk($sformatf("R3/R4 offset vec %0d", v), 64'(rsp_offset), 64'(VECS[v].off));
         chk($sformatf("R8 overlap vec %0d", v), 64'(flag_overlap), 64'(VECS[v].ovl));
         chk($sformatf("R9 slot flag vec %0d", v), 64'(flag_slot), 64'(VECS[v].serr));
         @(negedge clk);
         // R2: no request -> valid drops, result held
         chk($sformatf("R2 idle valid vec %0d", v), 64'(rsp_valid), 64'd0);
         chk($sformatf("R2 idle hold vec %0d", v), 64'(rsp_offset), 64'(VECS[v].off));
      end

      // R10: data-rate mixing
      cfg_cs0_size = 10'd8;  cfg_cs1_size = 10'd8;
      cfg_cs1_slot_hi = 4'd1; cfg_cs1_slot_lo = 2'd0;
      cfg_cs0_ddr = 1'b1;    cfg_cs1_ddr = 1'b0;
      @(negedge clk);
      chk("R10 mixed populated", 64'(flag_mix), 64'd1);
      cfg_cs1_size = 10'd0;
      @(negedge clk);
      chk("R10 empty device ignored", 64'(flag_mix), 64'd0);
      cfg_cs1_size = 10'd8;  cfg_cs1_ddr = 1'b1;
      @(negedge clk);
      chk("R10 same family", 64'(flag_mix), 64'd0);
      cfg_cs0_ddr = 1'b0;  cfg_cs1_ddr = 1'b1;
      @(negedge clk);
      chk("R10 mixed reversed", 64'(flag_mix), 64'd1);

      // R1: mid-run reset clears everything
      cfg_cs1_slot_hi = 4'd2;
      req_valid = 1'b1; req_addr = 30'h0000_0100;
      @(negedge clk);
      chk("R1 pre-reset valid", 64'(rsp_valid), 64'd1);
      rst_n = 1'b0;
      #1;
      outputs_zero("R1 mid-run reset");
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule